// File: doc/BRIEF.md
# Fault Severity Classifier with Reset Gating

This block sits between the protection detectors of a motor-driven appliance and its user interface. Nine detectors each report a fault by a one-cycle event strobe. The block files every event under a fixed severity level and keeps the code of each fault until that level's clearing rule holds. It always presents the single most important active code, with its level. It also asserts a restart-permit output only while the cool-down, interlock and retry-budget conditions hold together and no blocking fault is active.

Each level clears in its own way. Advisory faults never stop the machine and drop out once their evidence reads normal. Auto-recover faults block a restart and drop out once their evidence reads normal. User-action faults also need the lid stable closed and the unit cooled. Latched faults stay until the user holds the reset button long enough while the unit is cool and closed. A retry counter counts restarts made after stall-type faults. When the budget is spent, a further stall report escalates to the latched repeated-stall code. The counter returns to zero after a programmable stretch of fault-free running.

Top module: `fault_sev_gate`

## Requirements
- R1: Code k (1..9) is reported on `evt[k-1]`. The code and level table is: 1 lid not closed (level 2), 2 lid opened while running (2), 3 suspected stall (1), 4 repeated stall (3), 5 overheat warning (1), 6 overheat trip (3), 7 sensor open/short (2), 8 odor rise (0), 9 purge ineffective (0). Code 0 means no active fault.
- R2: `act_code`/`act_level` show the active fault with the highest level. Among equal levels the most recently reported fault is shown. Faults reported in the same cycle go to the higher code number.
- R3: An active level-0 fault never withdraws `restart_ok`. Any active fault of level 1, 2 or 3 forces `restart_ok` low.
- R4: A level-0 or level-1 fault clears on the first cycle in which its bit of `ev_ok` is high and it is not being reported again.
- R5: A level-2 fault clears only in a cycle where its `ev_ok` bit is high, `ilk_stable` is high and the unit is cool (`temp < cfg_temp_reset` and `slope_ok`).
- R6: A level-3 fault is latched. Evidence does not clear it. Only a recognised long press clears it, and only while `ilk_stable` is high and the unit is cool. Clearing the repeated-stall code also returns `retry_cnt` to 0.
- R7: A suspected-stall event that arrives while `retry_cnt >= cfg_retry_max` raises code 4 (repeated stall) instead of code 3.
- R8: `derate_req` is high exactly while the overheat warning (code 5) is active.
- R9: `restart_ok` = no active fault of level 1 or above, and `temp < cfg_temp_reset`, and `slope_ok`, and `ilk_stable`, and `retry_cnt < cfg_retry_max`.
- R10: `retry_cnt` rises by one on each `run_start` pulse that follows a stall-class event (code 3 or 4) since the counter was last cleared. It returns to 0 after `cfg_clean_ticks` ticks of `run_active` with no fault of level 1 or above. Without a prior stall event, `run_start` leaves it unchanged.
- R11: A long press is recognised when `btn_reset` stays high for `cfg_press_ticks` ticks. A shorter hold has no effect. One hold gives at most one recognition.
- R12: After reset, `act_code` is 0, `act_level` is 0 and `retry_cnt` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Time-base strobe for the press and clean-run timers |
| evt | input | 9 | Fault event strobes, bit k-1 for code k |
| ev_ok | input | 9 | Evidence-normal flag per code |
| temp | input | TW | Measured temperature |
| slope_ok | input | 1 | Temperature slope within normal range |
| ilk_stable | input | 1 | Interlock stable closed |
| btn_reset | input | 1 | User reset button level |
| run_start | input | 1 | One-cycle pulse when a run is started |
| run_active | input | 1 | Motor currently running |
| cfg_temp_reset | input | TW | Temperature below which reset and restart may proceed |
| cfg_press_ticks | input | PW | Hold length for a long press (0 disables) |
| cfg_clean_ticks | input | CW | Fault-free run length that clears the retry counter |
| cfg_retry_max | input | RW | Retry budget |
| act_code | output | 4 | Displayed fault code |
| act_level | output | 2 | Level of the displayed code |
| restart_ok | output | 1 | Restart permitted |
| derate_req | output | 1 | Derate and purge request |
| retry_cnt | output | RW | Restarts made after stall-type faults |

## Verification
The hardest state to reach is the escalation to the latched repeated-stall code. That state needs the retry budget to be exactly exhausted, and each retry needs a stall report, its evidence clearing and a run-start pulse, in that order. The stimulus repeats that three-step cycle until the counter meets the budget. It then confirms that the permit has dropped, fires one more stall and expects code 4 rather than code 3. Recovery is then checked through a long press made while the unit is cool. Recency ordering among equal levels is reached by reporting two level-2 faults in turn, then refreshing the older one.

// File: rtl/fsg_pkg.sv
`timescale 1ns/1ps
package fsg_pkg;
  localparam int NSRC   = 9;
  localparam int CODE_W = 4;

  typedef logic [1:0] lvl_t;

  // severity of each source, index = code - 1
  function automatic lvl_t src_level(input int unsigned idx);
    case (idx)
      0, 1, 6: src_level = 2'd2;
      2, 4:    src_level = 2'd1;
      3, 5:    src_level = 2'd3;
      default: src_level = 2'd0;
    endcase
  endfunction

  function automatic logic is_stall(input int unsigned idx);
    is_stall = (idx == 2) || (idx == 3);
  endfunction

  // unit is cool enough for restart or latch clearing
  function automatic logic cool_enough(input logic [31:0] t, input logic [31:0] lim,
                                       input logic slope);
    cool_enough = (t < lim) && slope;
  endfunction
endpackage

// File: rtl/fsg_press.sv
`timescale 1ns/1ps
module fsg_press #(
  parameter int PW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          btn,
  input  logic [PW-1:0] cfg_ticks,
  output logic          fire
);
  logic [PW-1:0] cnt;
  logic          done;
  logic [PW:0]   cnt_nx;

  assign cnt_nx = {1'b0, cnt} + {{PW{1'b0}}, 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      done <= 1'b0;
      fire <= 1'b0;
    end else if (!btn) begin
      cnt  <= '0;
      done <= 1'b0;
      fire <= 1'b0;
    end else begin
      fire <= 1'b0;
      if (tick && !done) begin
        if (cnt_nx == {1'b0, cfg_ticks}) begin
          fire <= 1'b1;
          done <= 1'b1;
        end
        cnt <= cnt_nx[PW-1:0];
      end
    end
  end
endmodule

// File: rtl/fsg_retry.sv
`timescale 1ns/1ps
module fsg_retry #(
  parameter int RW = 3,
  parameter int CW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          stall_evt,
  input  logic          run_start,
  input  logic          run_active,
  input  logic          blocked,
  input  logic          clr,
  input  logic [CW-1:0] cfg_clean,
  output logic [RW-1:0] cnt
);
  localparam logic [RW-1:0] CNT_MAX = '1;

  logic [CW-1:0] clean;
  logic          armed;
  logic [CW:0]   clean_nx;

  assign clean_nx = {1'b0, clean} + {{CW{1'b0}}, 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      clean <= '0;
      armed <= 1'b0;
    end else begin
      if (clr) begin
        cnt   <= '0;
        clean <= '0;
        armed <= 1'b0;
      end else begin
        if (run_start && armed && cnt != CNT_MAX)
          cnt <= cnt + RW'(1);
        if (!run_active || blocked) begin
          clean <= '0;
        end else if (tick) begin
          if (clean_nx >= {1'b0, cfg_clean}) begin
            clean <= '0;
            cnt   <= '0;
            armed <= 1'b0;
          end else begin
            clean <= clean_nx[CW-1:0];
          end
        end
      end
      if (stall_evt)
        armed <= 1'b1;
    end
  end
endmodule

// File: rtl/fsg_slots.sv
`timescale 1ns/1ps
module fsg_slots import fsg_pkg::*; #(
  parameter int AGE_W = 6
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NSRC-1:0]             evt,
  input  logic [NSRC-1:0]             ev_ok,
  input  logic                        cool_ok,
  input  logic                        ilk_stable,
  input  logic                        lp_fire,
  output logic [NSRC-1:0]             active,
  output logic [NSRC-1:0][AGE_W-1:0]  age
);
  localparam logic [AGE_W-1:0] AGE_MAX = '1;

  logic any_evt;
  assign any_evt = |evt;

  for (genvar i = 0; i < NSRC; i++) begin : g_slot
    localparam lvl_t LVL = src_level(i);
    logic clr_ok;

    if (LVL == 2'd3) begin : g_latch
      assign clr_ok = lp_fire && ilk_stable && cool_ok;
    end else if (LVL == 2'd2) begin : g_user
      assign clr_ok = ev_ok[i] && ilk_stable && cool_ok;
    end else begin : g_auto
      assign clr_ok = ev_ok[i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        active[i] <= 1'b0;
        age[i]    <= AGE_MAX;
      end else begin
        if (evt[i])
          active[i] <= 1'b1;
        else if (clr_ok)
          active[i] <= 1'b0;

        if (evt[i])
          age[i] <= '0;
        else if (any_evt && age[i] != AGE_MAX)
          age[i] <= age[i] + AGE_W'(1);
      end
    end
  end
endmodule

// File: rtl/fsg_pick.sv
`timescale 1ns/1ps
module fsg_pick import fsg_pkg::*; #(
  parameter int AGE_W = 6
) (
  input  logic [NSRC-1:0]            active,
  input  logic [NSRC-1:0][AGE_W-1:0] age,
  output logic [CODE_W-1:0]          code,
  output lvl_t                       level,
  output logic                       blocked
);
  localparam int KW = 2 + AGE_W + CODE_W;

  // larger key wins: level, then youngest, then higher code
  function automatic logic [KW-1:0] rank_key(input lvl_t l, input logic [AGE_W-1:0] a,
                                             input logic [CODE_W-1:0] c);
    rank_key = {l, ~a, c};
  endfunction

  logic [KW-1:0] best;
  logic          hit;

  always_comb begin
    best    = '0;
    hit     = 1'b0;
    code    = '0;
    level   = 2'd0;
    blocked = 1'b0;
    for (int i = 0; i < NSRC; i++) begin
      if (active[i]) begin
        if (src_level(i) != 2'd0)
          blocked = 1'b1;
        if (!hit || rank_key(src_level(i), age[i], CODE_W'(i + 1)) > best) begin
          best  = rank_key(src_level(i), age[i], CODE_W'(i + 1));
          hit   = 1'b1;
          code  = CODE_W'(i + 1);
          level = src_level(i);
        end
      end
    end
  end
endmodule

// File: rtl/fault_sev_gate.sv
`timescale 1ns/1ps
module fault_sev_gate import fsg_pkg::*; #(
  parameter int TW    = 10,
  parameter int PW    = 8,
  parameter int CW    = 12,
  parameter int RW    = 3,
  parameter int AGE_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic [8:0]        evt,
  input  logic [8:0]        ev_ok,
  input  logic [TW-1:0]     temp,
  input  logic              slope_ok,
  input  logic              ilk_stable,
  input  logic              btn_reset,
  input  logic              run_start,
  input  logic              run_active,
  input  logic [TW-1:0]     cfg_temp_reset,
  input  logic [PW-1:0]     cfg_press_ticks,
  input  logic [CW-1:0]     cfg_clean_ticks,
  input  logic [RW-1:0]     cfg_retry_max,
  output logic [3:0]        act_code,
  output logic [1:0]        act_level,
  output logic              restart_ok,
  output logic              derate_req,
  output logic [RW-1:0]     retry_cnt
);
  localparam int IDX_STALL = 2;
  localparam int IDX_REP   = 3;
  localparam int IDX_WARN  = 4;

  // named internal events, observed by the checker
  logic                       lp_fire;
  logic                       cool_ok;
  logic                       escalate;
  logic                       rep_clear;
  logic                       blocked;
  logic                       stall_evt;
  logic [NSRC-1:0]            evt_eff;
  logic [NSRC-1:0]            active;
  logic [NSRC-1:0][AGE_W-1:0] age;

  assign cool_ok  = cool_enough(32'(temp), 32'(cfg_temp_reset), slope_ok);
  assign escalate = evt[IDX_STALL] && (retry_cnt >= cfg_retry_max);

  always_comb begin
    evt_eff            = evt;
    evt_eff[IDX_STALL] = evt[IDX_STALL] && !escalate;
    evt_eff[IDX_REP]   = evt[IDX_REP] || escalate;
  end

  assign stall_evt = evt_eff[IDX_STALL] || evt_eff[IDX_REP];
  assign rep_clear = active[IDX_REP] && !evt_eff[IDX_REP] && lp_fire && ilk_stable && cool_ok;

  fsg_press #(.PW(PW)) u_press (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .btn       (btn_reset),
    .cfg_ticks (cfg_press_ticks),
    .fire      (lp_fire)
  );

  fsg_slots #(.AGE_W(AGE_W)) u_slots (
    .clk        (clk),
    .rst_n      (rst_n),
    .evt        (evt_eff),
    .ev_ok      (ev_ok),
    .cool_ok    (cool_ok),
    .ilk_stable (ilk_stable),
    .lp_fire    (lp_fire),
    .active     (active),
    .age        (age)
  );

  fsg_pick #(.AGE_W(AGE_W)) u_pick (
    .active  (active),
    .age     (age),
    .code    (act_code),
    .level   (act_level),
    .blocked (blocked)
  );

  fsg_retry #(.RW(RW), .CW(CW)) u_retry (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (tick),
    .stall_evt  (stall_evt),
    .run_start  (run_start),
    .run_active (run_active),
    .blocked    (blocked),
    .clr        (rep_clear),
    .cfg_clean  (cfg_clean_ticks),
    .cnt        (retry_cnt)
  );

  assign derate_req = active[IDX_WARN];
  assign restart_ok = !blocked && cool_ok && ilk_stable && (retry_cnt < cfg_retry_max);
endmodule

// File: rtl/fsg_checker.sv
`timescale 1ns/1ps
module fsg_checker #(
  parameter int TW = 10,
  parameter int RW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic [3:0]    act_code,
  input logic [1:0]    act_level,
  input logic          restart_ok,
  input logic          derate_req,
  input logic [RW-1:0] retry_cnt,
  input logic [RW-1:0] cfg_retry_max,
  input logic [TW-1:0] temp,
  input logic [TW-1:0] cfg_temp_reset,
  input logic          slope_ok,
  input logic          ilk_stable,
  input logic          lp_fire
);
  AST_PERMIT_GATES: assert property (@(posedge clk) disable iff (!rst_n)
    restart_ok |-> (temp < cfg_temp_reset) && slope_ok && ilk_stable && (retry_cnt < cfg_retry_max)); // R9

  AST_BLOCKING_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    (act_level != 2'd0) |-> !restart_ok); // R3

  AST_ADVISORY_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    ((act_level == 2'd0) && (temp < cfg_temp_reset) && slope_ok && ilk_stable
     && (retry_cnt < cfg_retry_max)) |-> restart_ok); // R3

  AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ((act_level == 2'd3) && !lp_fire) |=> (act_level == 2'd3)); // R6

  AST_RETRY_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (retry_cnt != $past(retry_cnt)) |-> ((retry_cnt == '0) || (retry_cnt == RW'($past(retry_cnt) + RW'(1))))); // R10

  AST_DERATE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    derate_req |-> (act_level != 2'd0)); // R8

  AST_IDLE_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    (act_code == 4'd0) |-> (act_level == 2'd0)); // R1
endmodule

bind fault_sev_gate fsg_checker #(.TW(TW), .RW(RW)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .act_code       (act_code),
  .act_level      (act_level),
  .restart_ok     (restart_ok),
  .derate_req     (derate_req),
  .retry_cnt      (retry_cnt),
  .cfg_retry_max  (cfg_retry_max),
  .temp           (temp),
  .cfg_temp_reset (cfg_temp_reset),
  .slope_ok       (slope_ok),
  .ilk_stable     (ilk_stable),
  .lp_fire        (lp_fire)
);

// File: tb/tb_fault_sev_gate.sv
`timescale 1ns/1ps
module tb_fault_sev_gate;
  localparam int TW = 10, PW = 8, CW = 12, RW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b1;
  logic [8:0] evt = '0, ev_ok = '0;
  logic [TW-1:0] temp = 10'd100, cfg_temp_reset = 10'd200;
  logic slope_ok = 1'b1, ilk_stable = 1'b1, btn_reset = 1'b0;
  logic run_start = 1'b0, run_active = 1'b0;
  logic [PW-1:0] cfg_press_ticks = 8'd4;
  logic [CW-1:0] cfg_clean_ticks = 12'd6;
  logic [RW-1:0] cfg_retry_max = 3'd2;
  logic [3:0] act_code;
  logic [1:0] act_level;
  logic restart_ok, derate_req;
  logic [RW-1:0] retry_cnt;

  int checks = 0, errors = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  fault_sev_gate #(.TW(TW), .PW(PW), .CW(CW), .RW(RW)) dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .evt(evt), .ev_ok(ev_ok), .temp(temp),
    .slope_ok(slope_ok), .ilk_stable(ilk_stable), .btn_reset(btn_reset),
    .run_start(run_start), .run_active(run_active), .cfg_temp_reset(cfg_temp_reset),
    .cfg_press_ticks(cfg_press_ticks), .cfg_clean_ticks(cfg_clean_ticks),
    .cfg_retry_max(cfg_retry_max), .act_code(act_code), .act_level(act_level),
    .restart_ok(restart_ok), .derate_req(derate_req), .retry_cnt(retry_cnt));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic report(input int code);
    evt[code-1] = 1'b1; step(1); evt = '0;
  endtask

  task automatic settle(input int code);
    ev_ok[code-1] = 1'b1; step(1); ev_ok[code-1] = 1'b0;
  endtask

  task automatic press(input int n);
    btn_reset = 1'b1; step(n); btn_reset = 1'b0; step(2);
  endtask

  task automatic start_run();
    run_start = 1'b1; step(1); run_start = 1'b0;
  endtask

  task automatic t_reset();
    chk("R12 code", act_code, 0);
    chk("R12 level", act_level, 0);
    chk("R12 retry", retry_cnt, 0);
    chk("R9 permit idle", restart_ok, 1);
  endtask

  task automatic t_priority();
    report(8);
    chk("R1 odor code", act_code, 8); chk("R1 odor level", act_level, 0);
    chk("R3 advisory permits", restart_ok, 1);
    report(5);
    chk("R2 warn above odor", act_code, 5); chk("R8 derate", derate_req, 1);
    chk("R3 level1 blocks", restart_ok, 0);
    report(2); chk("R2 lid run shown", act_code, 2);
    report(7); chk("R2 newer sensor", act_code, 7);
    report(2); chk("R2 refreshed lid", act_code, 2);
    ilk_stable = 1'b0; ev_ok[1] = 1'b1; ev_ok[6] = 1'b1; step(1);
    chk("R5 held open lid", act_code, 2); chk("R5 held level", act_level, 2);
    ilk_stable = 1'b1; step(1); ev_ok = '0;
    chk("R5 cleared to warn", act_code, 5);
    settle(5);
    chk("R4 warn cleared", act_code, 8); chk("R8 derate off", derate_req, 0);
    chk("R3 odor only permits", restart_ok, 1);
    settle(8); chk("R4 odor cleared", act_code, 0);
    evt[0] = 1'b1; evt[6] = 1'b1; step(1); evt = '0;
    chk("R2 same cycle higher code", act_code, 7);
    ev_ok[0] = 1'b1; ev_ok[6] = 1'b1; step(1); ev_ok = '0;
    chk("R5 both cleared", act_code, 0);
  endtask

  task automatic t_latch();
    report(6);
    chk("R6 trip code", act_code, 6); chk("R6 trip level", act_level, 3);
    ev_ok = '1; step(2); ev_ok = '0;
    chk("R6 evidence ignored", act_code, 6);
    press(2); chk("R11 short press ignored", act_code, 6);
    temp = 10'd300; press(5); chk("R6 hot press ignored", act_code, 6);
    chk("R9 hot no permit", restart_ok, 0);
    temp = 10'd100; press(5); chk("R6 long press clears", act_code, 0);
  endtask

  task automatic t_retry();
    for (int k = 1; k <= 2; k++) begin
      report(3);
      chk("R1 stall level", act_level, 1);
      settle(3); start_run();
      chk("R10 retry step", retry_cnt, k);
    end
    chk("R9 budget spent", restart_ok, 0);
    report(3);
    chk("R7 escalated code", act_code, 4); chk("R7 latched level", act_level, 3);
    press(5);
    chk("R6 rep cleared", act_code, 0); chk("R6 retry zeroed", retry_cnt, 0);
    chk("R9 permit back", restart_ok, 1);
    start_run(); chk("R10 unarmed start", retry_cnt, 0);
  endtask

  task automatic t_clean();
    report(3); settle(3); start_run();
    chk("R10 armed start", retry_cnt, 1);
    run_active = 1'b1; step(4);
    chk("R10 before clean window", retry_cnt, 1);
    step(4);
    chk("R10 after clean window", retry_cnt, 0);
    run_active = 1'b0;
  endtask

  initial begin
    step(3); rst_n = 1'b1; step(1);
    t_reset();
    t_priority();
    t_latch();
    t_retry();
    t_clean();
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #800000;
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule